// File: doc/BRIEF.md
# Register-Driven SPI Host with Byte Queues

This block is an SPI master that a processor drives through a small 32-bit register window. Software queues bytes into a transmit queue and takes captured bytes from a receive queue. Both queues are byte-wide and 256 entries deep by default. A serial engine sends each queued byte out and captures one byte from the target for every byte it sends. Chip-select lines are plain register bits that software sets and clears. Four single-cycle event strobes go to an external interrupt collector.

A control bit can inhibit transfers. Software sets it, loads a whole message, then clears it, and the engine sends the message back to back. Two write-only control bits empty either queue. A keyed write returns the whole block to its power-up state. All accesses are aligned 32-bit words, and the data registers use bits [7:0] only. A read returns its data in the cycle after the read strobe.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, status (0x64) reads 0x5, control (0x60) reads 0, both occupancy registers read 0, every ss_n line is high and sclk is low.
- R2: Bytes written to 0x68 are sent in write order, MSB first, in SPI mode 0: sclk idles low, the target samples on the rising edge, and mosi changes only after a falling edge. Each byte sent captures one byte. That byte goes into the receive queue and is read from 0x6C in bits [7:0], and ev_rx_stored pulses once for it.
- R3: A read of 0x6C while the receive queue is empty returns 0xDEADBEEF and removes nothing.
- R4: While control bit 8 is 1, written bytes stay queued and no transfer starts. Clearing the bit sends every queued byte. ev_tx_drained pulses when a byte completes with the transmit queue empty.
- R5: A control write with bit 5 set empties the transmit queue, and one with bit 6 set empties the receive queue. Neither bit is stored: control reads back only bit 8.
- R6: Writing exactly 0x0000000A to 0x40 resets all state: queues, control, select and engine. Any other value written there has no effect.
- R7: Bits [NUM_SS-1:0] of the select register (0x70) drive ss_n directly. A 0 bit asserts its line low. The register reads back at 0x70.
- R8: When the transmit queue holds DEPTH bytes, status bit 3 is 1 and further writes to 0x68 are dropped.
- R9: A byte captured while the receive queue is full is discarded and ev_rx_overrun pulses. ev_rx_full pulses when a stored byte fills the queue, and status bit 1 is then 1.
- R10: Status bits are: bit 3 transmit full, bit 2 transmit empty, bit 1 receive full, bit 0 receive empty. 0x74 and 0x78 read the transmit and receive queue occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Byte offset of the word accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to targets |
| miso | input | 1 | Serial data from the selected target |
| ss_n | output | NUM_SS | Active-low chip selects |
| ev_rx_stored | output | 1 | Pulse: a captured byte entered the receive queue |
| ev_rx_full | output | 1 | Pulse: the receive queue became full |
| ev_rx_overrun | output | 1 | Pulse: a captured byte was discarded |
| ev_tx_drained | output | 1 | Pulse: a byte completed with nothing left queued |

## Verification
The assertions assume at most one of reg_wr and reg_rd in any cycle. They also assume miso is settled before the clock edge at which the engine raises sclk. The bench keeps to this: its tasks issue one access at a time on the falling clock edge, and its target model changes miso only after an sclk edge. Soft reset is written only while the engine is idle, so the bench target stays aligned to byte boundaries.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [6:0] OFS_SOFTRST = 7'h40;
  localparam logic [6:0] OFS_CTRL    = 7'h60;
  localparam logic [6:0] OFS_STAT    = 7'h64;
  localparam logic [6:0] OFS_TXD     = 7'h68;
  localparam logic [6:0] OFS_RXD     = 7'h6C;
  localparam logic [6:0] OFS_SEL     = 7'h70;
  localparam logic [6:0] OFS_TXOCC   = 7'h74;
  localparam logic [6:0] OFS_RXOCC   = 7'h78;

  localparam int CTL_TXFLUSH = 5;
  localparam int CTL_RXFLUSH = 6;
  localparam int CTL_INHIBIT = 8;

  localparam logic [31:0] SOFTRST_KEY = 32'h0000_000A;
  localparam logic [31:0] EMPTY_WORD  = 32'hDEAD_BEEF;

  typedef struct packed {
    logic stored;
    logic full;
    logic overrun;
    logic drained;
  } spi_evt_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];
  assign count   = cnt_q;

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push && !flush)
      mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DCW-1:0] div_cnt;
  logic [2:0]     bit_cnt;
  logic [7:0]     tx_sh, rx_sh;
  logic           sclk_q, busy_q, done_q;

  assign sclk = sclk_q;
  assign mosi = tx_sh[7];
  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          tx_sh   <= tx_byte;
          bit_cnt <= '0;
          div_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (div_cnt == DCW'(DIV - 1)) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_cnt == 3'd7) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            rx_byte <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DIV    = 2,
  parameter int NUM_SS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n,
  output logic              ev_rx_stored,
  output logic              ev_rx_full,
  output logic              ev_rx_overrun,
  output logic              ev_tx_drained
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          soft_req, rst_all, ctl_wr;
  logic          tx_flush, rx_flush, tx_push, rx_pop, rx_pop_eff;
  logic          inhibit_q;
  logic [NUM_SS-1:0] sel_q;
  logic [7:0]    tx_head, rx_head, eng_rx;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          eng_busy, eng_done, eng_start;
  spi_evt_t      evt_d, evt_q;

  assign soft_req = reg_wr && (reg_addr == OFS_SOFTRST) && (reg_wdata == SOFTRST_KEY);
  assign rst_all  = rst || soft_req;
  assign ctl_wr   = reg_wr && (reg_addr == OFS_CTRL);
  assign tx_flush = ctl_wr && reg_wdata[CTL_TXFLUSH];
  assign rx_flush = ctl_wr && reg_wdata[CTL_RXFLUSH];
  assign tx_push  = reg_wr && (reg_addr == OFS_TXD);
  assign rx_pop   = reg_rd && (reg_addr == OFS_RXD);
  assign rx_pop_eff = rx_pop && !rx_empty;

  // a new byte starts only when idle, uninhibited and not racing a control write
  assign eng_start = !eng_busy && !inhibit_q && !tx_empty && !ctl_wr;

  byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst_all), .flush(tx_flush),
    .push(tx_push), .din(reg_wdata[7:0]),
    .pop(eng_start), .dout(tx_head),
    .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst_all), .flush(rx_flush),
    .push(eng_done), .din(eng_rx),
    .pop(rx_pop), .dout(rx_head),
    .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  spi_shifter #(.DIV(DIV)) u_eng (
    .clk(clk), .rst(rst_all), .start(eng_start), .tx_byte(tx_head),
    .miso(miso), .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
    .sclk(sclk), .mosi(mosi)
  );

  always_comb begin
    evt_d.stored  = eng_done && !rx_flush && (!rx_full || rx_pop_eff);
    evt_d.overrun = eng_done && !rx_flush && rx_full && !rx_pop_eff;
    evt_d.full    = evt_d.stored && !rx_pop_eff && (rx_cnt == CW'(DEPTH - 1));
    evt_d.drained = eng_done && tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      evt_q     <= '0;
      inhibit_q <= 1'b0;
      sel_q     <= '1;
    end else begin
      evt_q <= evt_d;
      if (ctl_wr)
        inhibit_q <= reg_wdata[CTL_INHIBIT];
      if (reg_wr && (reg_addr == OFS_SEL))
        sel_q <= reg_wdata[NUM_SS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL:  reg_rdata <= 32'(inhibit_q) << CTL_INHIBIT;
        OFS_STAT:  reg_rdata <= {28'd0, tx_full, tx_empty, rx_full, rx_empty};
        OFS_RXD:   reg_rdata <= rx_empty ? EMPTY_WORD : {24'd0, rx_head};
        OFS_SEL:   reg_rdata <= 32'(sel_q);
        OFS_TXOCC: reg_rdata <= 32'(tx_cnt);
        OFS_RXOCC: reg_rdata <= 32'(rx_cnt);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign ss_n          = sel_q;
  assign ev_rx_stored  = evt_q.stored;
  assign ev_rx_full    = evt_q.full;
  assign ev_rx_overrun = evt_q.overrun;
  assign ev_tx_drained = evt_q.drained;
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
  parameter int DEPTH  = 256,
  parameter int NUM_SS = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sclk,
  input logic                     mosi,
  input logic [NUM_SS-1:0]        ss_n,
  input logic                     reg_rd,
  input logic [6:0]               reg_addr,
  input logic [31:0]              reg_rdata,
  input logic                     ev_rx_overrun,
  input logic [$clog2(DEPTH):0]   rx_cnt,
  input logic [$clog2(DEPTH):0]   tx_cnt,
  input logic                     inhibit_q,
  input logic                     eng_busy,
  input logic                     rx_empty
);
  AST_SS_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (&ss_n)); // R1

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !sclk); // R2

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R2

  AST_EMPTY_READ_WORD: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 7'h6C && rx_empty) |=> (reg_rdata == 32'hDEADBEEF)); // R3

  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (inhibit_q && !eng_busy) |=> !eng_busy); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= ($clog2(DEPTH)+1)'(DEPTH)) && (rx_cnt <= ($clog2(DEPTH)+1)'(DEPTH))); // R8

  AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    ev_rx_overrun |-> ($past(rx_cnt) == ($clog2(DEPTH)+1)'(DEPTH))); // R9
endmodule

bind spi_host_ctrl spi_host_chk #(.DEPTH(DEPTH), .NUM_SS(NUM_SS)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ev_rx_overrun(ev_rx_overrun), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .inhibit_q(inhibit_q), .eng_busy(eng_busy), .rx_empty(rx_empty)
);

// File: tb/sim_spi_host_ctrl.sv
`timescale 1ns/1ps
module sim_spi_host_ctrl;
  localparam int DEPTH  = 256;
  localparam int DIV    = 2;
  localparam int NUM_SS = 2;
  localparam logic [7:0] RESP_BASE = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sclk, mosi, miso;
  logic [NUM_SS-1:0] ss_n;
  logic ev_rx_stored, ev_rx_full, ev_rx_overrun, ev_tx_drained;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_host_ctrl #(.DEPTH(DEPTH), .DIV(DIV), .NUM_SS(NUM_SS)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
    .ev_rx_stored(ev_rx_stored), .ev_rx_full(ev_rx_full),
    .ev_rx_overrun(ev_rx_overrun), .ev_tx_drained(ev_tx_drained)
  );

  // target model: captures mosi on rising sclk, answers RESP_BASE + frame index
  logic [7:0] cap_mem [512];
  int         cap_n = 0;
  logic [2:0] s_bit = '0;
  logic [7:0] s_sh  = '0;
  logic [7:0] resp;
  assign resp = RESP_BASE + 8'(cap_n);
  assign miso = resp[3'd7 - s_bit];

  always @(posedge sclk) begin
    s_sh  <= {s_sh[6:0], mosi};
    s_bit <= s_bit + 1'b1;
    if (s_bit == 3'd7) begin
      if (cap_n < 512) cap_mem[cap_n] <= {s_sh[6:0], mosi};
      cap_n <= cap_n + 1;
    end
  end

  int n_stored = 0, n_full = 0, n_over = 0, n_drain = 0;
  always @(posedge clk) begin
    if (ev_rx_stored)  n_stored <= n_stored + 1;
    if (ev_rx_full)    n_full   <= n_full + 1;
    if (ev_rx_overrun) n_over   <= n_over + 1;
    if (ev_tx_drained) n_drain  <= n_drain + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_drain();
    logic [31:0] occ;
    for (int i = 0; i < 20000; i++) begin
      rd(7'h74, occ);
      if (occ == 0) break;
    end
    repeat (50) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(7'h64, v); chk("R1 status after reset", v, 32'h5);
    rd(7'h60, v); chk("R1 control after reset", v, 32'h0);
    rd(7'h74, v); chk("R1 tx occupancy after reset", v, 32'h0);
    rd(7'h78, v); chk("R1 rx occupancy after reset", v, 32'h0);
    chk("R1 ss_n after reset", 32'(ss_n), 32'h3);
    chk("R1 sclk idle", 32'(sclk), 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    logic [7:0] txb [3];
    int k0, d0, s0;
    txb[0] = 8'hA5; txb[1] = 8'h81; txb[2] = 8'h1E;
    k0 = cap_n; d0 = n_drain; s0 = n_stored;
    for (int i = 0; i < 3; i++) wr(7'h68, {24'hFFFFFF, txb[i]});
    wait_drain();
    for (int i = 0; i < 3; i++)
      chk("R2 mosi byte order MSB first", 32'(cap_mem[k0+i]), 32'(txb[i]));
    rd(7'h78, v); chk("R10 rx occupancy after three bytes", v, 32'd3);
    rd(7'h64, v); chk("R10 status tx empty and rx holding", v, 32'h4);
    chk("R2 stored event count", n_stored - s0, 3);
    chk("R4 drained event once", n_drain - d0, 1);
    for (int i = 0; i < 3; i++) begin
      rd(7'h6C, v); chk("R2 captured byte", v, 32'(RESP_BASE + 8'(k0 + i)));
    end
    rd(7'h64, v); chk("R10 status after emptying rx", v, 32'h5);
  endtask

  task automatic t_empty_read();
    logic [31:0] v;
    rd(7'h6C, v); chk("R3 empty read word", v, 32'hDEADBEEF);
    rd(7'h78, v); chk("R3 rx occupancy unchanged", v, 32'h0);
  endtask

  task automatic t_inhibit();
    logic [31:0] v;
    int k0;
    k0 = cap_n;
    wr(7'h60, 32'h100);
    rd(7'h60, v); chk("R4 inhibit reads back", v, 32'h100);
    wr(7'h68, 32'h5A); wr(7'h68, 32'hC3);
    repeat (200) @(negedge clk);
    rd(7'h74, v); chk("R4 bytes held while inhibited", v, 32'd2);
    chk("R4 no frames while inhibited", cap_n - k0, 0);
    wr(7'h60, 32'h0);
    wait_drain();
    chk("R4 frames after release", cap_n - k0, 2);
    chk("R4 first released byte", 32'(cap_mem[k0]), 32'h5A);
    rd(7'h78, v); chk("R4 rx holds released bytes", v, 32'd2);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    int k0;
    wr(7'h60, 32'h140);
    rd(7'h60, v); chk("R5 rx flush bit not stored", v, 32'h100);
    rd(7'h78, v); chk("R5 rx queue emptied", v, 32'h0);
    wr(7'h68, 32'h11); wr(7'h68, 32'h22); wr(7'h68, 32'h33);
    rd(7'h74, v); chk("R5 tx queued before flush", v, 32'd3);
    wr(7'h60, 32'h120);
    rd(7'h74, v); chk("R5 tx queue emptied", v, 32'h0);
    rd(7'h60, v); chk("R5 tx flush bit not stored", v, 32'h100);
    k0 = cap_n;
    wr(7'h60, 32'h0);
    repeat (200) @(negedge clk);
    chk("R5 nothing sent after tx flush", cap_n - k0, 0);
  endtask

  task automatic t_select_softreset();
    logic [31:0] v;
    wr(7'h70, 32'h2);
    @(negedge clk);
    chk("R7 ss_n follows select", 32'(ss_n), 32'h2);
    rd(7'h70, v); chk("R7 select reads back", v, 32'h2);
    wr(7'h40, 32'h5);
    wr(7'h40, 32'h10A);
    @(negedge clk);
    chk("R6 wrong key ignored", 32'(ss_n), 32'h2);
    wr(7'h60, 32'h100);
    wr(7'h68, 32'h99);
    wr(7'h40, 32'hA);
    @(negedge clk);
    chk("R6 key restores select", 32'(ss_n), 32'h3);
    rd(7'h60, v); chk("R6 key clears control", v, 32'h0);
    rd(7'h74, v); chk("R6 key empties tx", v, 32'h0);
    rd(7'h64, v); chk("R6 status after key", v, 32'h5);
  endtask

  task automatic t_full_overrun();
    logic [31:0] v;
    int k0, f0, o0;
    k0 = cap_n; f0 = n_full; o0 = n_over;
    wr(7'h60, 32'h100);
    for (int i = 0; i < DEPTH; i++) wr(7'h68, 32'(i));
    rd(7'h64, v); chk("R8 status tx full", v, 32'h9);
    wr(7'h68, 32'hEE);
    rd(7'h74, v); chk("R8 extra write dropped", v, 32'(DEPTH));
    wr(7'h60, 32'h0);
    wait_drain();
    chk("R8 frames sent", cap_n - k0, DEPTH);
    chk("R8 last sent byte", 32'(cap_mem[k0 + DEPTH - 1]), 32'hFF);
    rd(7'h64, v); chk("R9 status rx full", v, 32'h6);
    chk("R9 full event once", n_full - f0, 1);
    chk("R9 no overrun yet", n_over - o0, 0);
    wr(7'h68, 32'h77);
    wait_drain();
    chk("R9 overrun event", n_over - o0, 1);
    rd(7'h78, v); chk("R9 rx occupancy capped", v, 32'(DEPTH));
    rd(7'h6C, v); chk("R9 oldest byte kept", v, 32'(RESP_BASE + 8'(k0)));
    wr(7'h60, 32'h40);
    rd(7'h78, v); chk("R5 rx flush after overrun", v, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty_read();
    t_inhibit();
    t_flush();
    t_select_softreset();
    t_full_overrun();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..all actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule